// File: doc/BRIEF.md
# Four-Channel Synchronized DAC Register Bank

This block holds the digital side of a four-channel digital-to-analog output stage. A small register bus writes a 12-bit code for each channel and a packed set of 2-bit range selects. The block drives the four codes and the range field in parallel to the converters. The converters themselves sit outside the block.

There are two output modes. In synchronous mode a data write lands only in the channel's holding register, and a write to the update address moves all four holding values to the outputs on one clock edge. In immediate mode a data write also updates that channel's output at once. Range changes reach the outputs at once in both modes.

After reset the block is in synchronous mode. Every code is mid-scale (0x800) and every range select is bipolar (2'b10).

The register bus has no back-pressure: the block accepts one read or write on every cycle. Read data is registered. It appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.

Top module: `dacbank_sync_top`

## Requirements
- R1: While reset is asserted and after it is released, every channel code is 0x800, the range field is 0xAA, the synchronous-mode bit reads 1 and `bus_rdata` is 0.
- R2: A word write (`bus_byte`=0) at even offset 2n, for n from 0 to 3, loads channel n's holding register from `bus_wdata[11:0]`. Bits 15:12 are ignored.
- R3: A byte write at offset 2n replaces holding bits 7:0 with `bus_wdata[7:0]`. A write of any size at offset 2n+1 replaces holding bits 11:8 with `bus_wdata[3:0]`. The other bits are kept.
- R4: With synchronous mode on, data writes leave all four output codes unchanged.
- R5: With synchronous mode on, a write of any size at offset 9 copies all four holding registers to the outputs. All four outputs change after that one clock edge.
- R6: With synchronous mode off, a data write changes the addressed channel's output to the new holding value after the same clock edge, and a write at offset 9 has no effect on the outputs.
- R7: A write at offset 8 loads the range register from `bus_wdata[7:0]`, with channel n in bits 2n+1:2n. The new value drives `range_o` after that edge in either mode, and the register reads back as {8'h00, range}.
- R8: A write at offset 15 sets synchronous mode from `bus_wdata[0]` (1 = synchronous). A read there returns that bit in bit 0, with zeros above.
- R9: A read at offset 2n returns {4'h0, holding code}, and a read at 2n+1 returns holding bits 11:8 in bits 3:0.
- R10: A read of a data register returns the holding value, not the code being driven.
- R11: Offsets 9 to 14 read as 0. A write at offsets 10 to 14 changes no output.
- R12: When a read and a write hit the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_byte | input | 1 | 1 = byte access (data on bits 7:0), 0 = word access |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dac_code_o | output | 48 | Channel n code in bits 12n+11:12n |
| range_o | output | 8 | Range selects, 2 bits per channel |

## Verification
If a holding register goes wrong, the outputs do not show it in synchronous mode until the next update write. In that mode the error can only be seen at once through a data-register readback, so the bench reads holding values back before it strobes. If an output register goes wrong, `dac_code_o` shows it in the cycle after the faulty edge. The bench checks every channel after each write, so a neighbour channel that moves by mistake is also caught. A fault in the range register or in the mode bit shows after one edge, on `range_o` or on the behaviour of the next data write.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned BUS_W = 16;
  localparam int unsigned LO_W  = 8;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_DATA,
    REG_RANGE,
    REG_STROBE,
    REG_CTRL
  } reg_kind_e;
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 4,
  parameter int SYNC_ADDR = 15,
  localparam int HI_W     = CODE_W - LO_W,
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              bus_wr,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output reg_kind_e         kind,
  output logic [CH_W-1:0]   sel_ch,
  output logic              sel_hi,
  output logic [NCH-1:0]    we_lo,
  output logic [NCH-1:0]    we_hi,
  output logic [LO_W-1:0]   lo_data,
  output logic [HI_W-1:0]   hi_data,
  output logic              range_we,
  output logic              strobe,
  output logic              ctrl_we
);
  localparam int DATA_END = 2 * NCH;
  localparam int RANGE_AD = DATA_END;
  localparam int STRB_AD  = DATA_END + 1;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    kind = REG_NONE;
    if (bus_addr < ADDR_W'(DATA_END))            kind = REG_DATA;
    else if (bus_addr == ADDR_W'(RANGE_AD))      kind = REG_RANGE;
    else if (bus_addr == ADDR_W'(STRB_AD))       kind = REG_STROBE;
    else if (bus_addr == ADDR_W'(SYNC_ADDR))     kind = REG_CTRL;
  end

  assign sel_ch = bus_addr[CH_W:1];
  assign sel_hi = bus_addr[0];

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_we
      logic hit;
      assign hit       = bus_wr && (kind == REG_DATA) && (sel_ch == CH_W'(ch));
      assign we_lo[ch] = hit && !sel_hi;
      assign we_hi[ch] = hit && (sel_hi || !bus_byte);
    end
  endgenerate

  assign lo_data  = bus_wdata[LO_W-1:0];
  assign hi_data  = sel_hi ? bus_wdata[HI_W-1:0] : bus_wdata[LO_W +: HI_W];
  assign range_we = bus_wr && (kind == REG_RANGE);
  assign strobe   = bus_wr && (kind == REG_STROBE);
  assign ctrl_we  = bus_wr && (kind == REG_CTRL);
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
#(
  parameter int                CODE_W   = 12,
  parameter logic [CODE_W-1:0] RST_CODE = 'h800,
  localparam int               HI_W     = CODE_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [LO_W-1:0]   lo_data,
  input  logic [HI_W-1:0]   hi_data,
  input  logic              sync_mode,
  input  logic              load,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] out_o
);
  logic [CODE_W-1:0] hold_q, out_q, hold_nx;
  logic              any_we;

  assign any_we = we_lo || we_hi;

  always_comb begin
    hold_nx = hold_q;
    if (we_lo) hold_nx[LO_W-1:0]      = lo_data;
    if (we_hi) hold_nx[CODE_W-1:LO_W] = hi_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= RST_CODE;
      out_q  <= RST_CODE;
    end else begin
      if (any_we) hold_q <= hold_nx;
      if (!sync_mode && any_we) out_q <= hold_nx;
      else if (load)            out_q <= hold_q;
    end
  end

  assign hold_o = hold_q;
  assign out_o  = out_q;
endmodule

// File: rtl/dacbank_rdmux.sv
module dacbank_rdmux
  import dacbank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RNG_W = 2 * NCH
) (
  input  reg_kind_e             kind,
  input  logic [CH_W-1:0]       sel_ch,
  input  logic                  sel_hi,
  input  logic [NCH*CODE_W-1:0] hold_flat,
  input  logic [RNG_W-1:0]      range_q,
  input  logic                  sync_q,
  output logic [BUS_W-1:0]      rd_word
);
  logic [CODE_W-1:0] cur;

  always_comb begin
    cur     = hold_flat[sel_ch*CODE_W +: CODE_W];
    rd_word = '0;
    case (kind)
      REG_DATA:  rd_word = sel_hi ? BUS_W'(cur[CODE_W-1:LO_W]) : BUS_W'(cur);
      REG_RANGE: rd_word = BUS_W'(range_q);
      REG_CTRL:  rd_word = BUS_W'(sync_q);
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/dacbank_sync_top.sv
module dacbank_sync_top
  import dacbank_pkg::*;
#(
  parameter int                NCH       = 4,
  parameter int                CODE_W    = 12,
  parameter int                ADDR_W    = 4,
  parameter int                SYNC_ADDR = 15,
  parameter logic [CODE_W-1:0] RST_CODE  = 'h800,
  parameter logic [1:0]        RST_RANGE = 2'b10,
  parameter logic              RST_SYNC  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic                  bus_byte,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  output logic [NCH*CODE_W-1:0] dac_code_o,
  output logic [2*NCH-1:0]      range_o
);
  localparam int HI_W  = CODE_W - LO_W;
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RNG_W = 2 * NCH;

  reg_kind_e             kind;
  logic [CH_W-1:0]       sel_ch;
  logic                  sel_hi;
  logic [NCH-1:0]        we_lo, we_hi;
  logic [LO_W-1:0]       lo_data;
  logic [HI_W-1:0]       hi_data;
  logic                  range_we, strobe, ctrl_we;
  logic [NCH*CODE_W-1:0] hold_flat;
  logic [RNG_W-1:0]      range_q;
  logic                  sync_q;
  logic [BUS_W-1:0]      rd_word;

  dacbank_decode #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)
  ) decode_i (
    .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .kind(kind), .sel_ch(sel_ch), .sel_hi(sel_hi),
    .we_lo(we_lo), .we_hi(we_hi), .lo_data(lo_data), .hi_data(hi_data),
    .range_we(range_we), .strobe(strobe), .ctrl_we(ctrl_we)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      dacbank_chan #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) chan_i (
        .clk(clk), .rst_n(rst_n),
        .we_lo(we_lo[ch]), .we_hi(we_hi[ch]),
        .lo_data(lo_data), .hi_data(hi_data),
        .sync_mode(sync_q), .load(strobe && sync_q),
        .hold_o(hold_flat[ch*CODE_W +: CODE_W]),
        .out_o(dac_code_o[ch*CODE_W +: CODE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_q <= {NCH{RST_RANGE}};
      sync_q  <= RST_SYNC;
    end else begin
      if (range_we) range_q <= bus_wdata[RNG_W-1:0];
      if (ctrl_we)  sync_q  <= bus_wdata[0];
    end
  end

  dacbank_rdmux #(.NCH(NCH), .CODE_W(CODE_W)) rdmux_i (
    .kind(kind), .sel_ch(sel_ch), .sel_hi(sel_hi), .hold_flat(hold_flat),
    .range_q(range_q), .sync_q(sync_q), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assign range_o = range_q;
endmodule

// File: rtl/dacbank_sync_chk.sv
module dacbank_sync_chk #(
  parameter int NCH       = 4,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 4,
  parameter int SYNC_ADDR = 15,
  localparam int RNG_W    = 2 * NCH
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_byte,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [15:0]           bus_wdata,
  input logic [NCH*CODE_W-1:0] dac_code_o,
  input logic [RNG_W-1:0]      range_o,
  input logic                  sync_q,
  input logic [NCH*CODE_W-1:0] hold_flat
);
  localparam logic [ADDR_W-1:0] RANGE_AD = ADDR_W'(2 * NCH);
  localparam logic [ADDR_W-1:0] STRB_AD  = ADDR_W'(2 * NCH + 1);
  localparam logic [ADDR_W-1:0] CTRL_AD  = ADDR_W'(SYNC_ADDR);

  logic unused_chk;
  assign unused_chk = ^bus_wdata;

  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr < RANGE_AD && sync_q) |=> $stable(dac_code_o));

  // R5
  strobe_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STRB_AD && sync_q) |=> (dac_code_o == $past(hold_flat)));

  // R6
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STRB_AD && !sync_q) |=> $stable(dac_code_o));

  // R6
  imm_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_byte && bus_addr == '0 && !sync_q)
      |=> (dac_code_o[CODE_W-1:0] == $past(bus_wdata[CODE_W-1:0])));

  // R7
  range_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RANGE_AD) |=> (range_o == $past(bus_wdata[RNG_W-1:0])));

  // R7
  range_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == RANGE_AD) |=> $stable(range_o));

  // R8
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_AD) |=> (sync_q == $past(bus_wdata[0])));
endmodule

bind dacbank_sync_top dacbank_sync_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_byte(bus_byte),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dac_code_o(dac_code_o),
  .range_o(range_o), .sync_q(sync_q), .hold_flat(hold_flat)
);

// File: tb/dacbank_sync_top_tb_top.sv
module dacbank_sync_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [47:0] dac_code_o;
  logic [7:0]  range_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_out [4];
  logic [7:0]  exp_rng;

  always #4 clk = ~clk;

  dacbank_sync_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dac_code_o(dac_code_o), .range_o(range_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    for (int ch = 0; ch < 4; ch++)
      check(tag, 32'(dac_code_o[ch*12 +: 12]), 32'(exp_out[ch]));
    check(tag, 32'(range_o), 32'(exp_rng));
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic by);
    bus_addr = a; bus_wdata = d; bus_byte = by; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int ch = 0; ch < 4; ch++) exp_out[ch] = 12'h800;
    exp_rng = 8'hAA;
    check("R1 rdata", 32'(bus_rdata), 32'h0);
    check_outs("R1 outputs");
    bus_read(4'd15, d);
    check("R1 sync bit", 32'(d), 32'h1);
  endtask

  task automatic t_sync_hold();
    logic [15:0] d;
    bus_write(4'd0, 16'h1123, 1'b0);
    bus_write(4'd2, 16'h0456, 1'b0);
    bus_write(4'd4, 16'h0789, 1'b0);
    bus_write(4'd6, 16'h0ABC, 1'b0);
    check_outs("R4 no change in sync mode");
    bus_read(4'd4, d);
    check("R10 hold not output ch2", 32'(d), 32'h0789);
    bus_read(4'd0, d);
    check("R2 upper bits ignored ch0", 32'(d), 32'h0123);
    bus_write(4'd9, 16'h0000, 1'b1);
    exp_out[0] = 12'h123; exp_out[1] = 12'h456;
    exp_out[2] = 12'h789; exp_out[3] = 12'hABC;
    check_outs("R5 strobe copies all");
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    bus_write(4'd2, 16'hFF5A, 1'b1);
    bus_read(4'd2, d);
    check("R3 low byte ch1", 32'(d), 32'h045A);
    bus_write(4'd3, 16'h00F7, 1'b1);
    bus_read(4'd3, d);
    check("R9 high nibble read ch1", 32'(d), 32'h0007);
    bus_read(4'd2, d);
    check("R3 merged ch1", 32'(d), 32'h075A);
    check_outs("R4 byte writes held");
    bus_write(4'd9, 16'h0000, 1'b0);
    exp_out[1] = 12'h75A;
    check_outs("R5 strobe after byte writes");
  endtask

  task automatic t_immediate();
    logic [15:0] d;
    bus_write(4'd0, 16'h000F, 1'b1);
    check_outs("R4 ch0 held");
    bus_write(4'd15, 16'hFFFE, 1'b0);
    bus_read(4'd15, d);
    check("R8 sync off readback", 32'(d), 32'h0);
    bus_write(4'd9, 16'h0000, 1'b1);
    check_outs("R6 strobe ignored");
    bus_write(4'd6, 16'h0321, 1'b0);
    exp_out[3] = 12'h321;
    check_outs("R6 immediate word ch3");
    bus_write(4'd5, 16'h0009, 1'b1);
    exp_out[2] = 12'h989;
    check_outs("R6 immediate nibble ch2");
    bus_write(4'd15, 16'h0003, 1'b0);
    bus_read(4'd15, d);
    check("R8 sync on readback", 32'(d), 32'h1);
    bus_write(4'd9, 16'h0000, 1'b1);
    exp_out[0] = 12'h10F;
    check_outs("R5 strobe releases ch0");
  endtask

  task automatic t_range();
    logic [15:0] d;
    bus_write(4'd8, 16'h121B, 1'b0);
    exp_rng = 8'h1B;
    check_outs("R7 range word in sync mode");
    bus_read(4'd8, d);
    check("R7 range readback", 32'(d), 32'h001B);
    bus_write(4'd8, 16'h00E4, 1'b1);
    exp_rng = 8'hE4;
    check_outs("R7 range byte");
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    bus_write(4'd12, 16'hFFFF, 1'b0);
    check_outs("R11 unmapped write");
    bus_read(4'd12, d);
    check("R11 unmapped read", 32'(d), 32'h0);
    bus_read(4'd9, d);
    check("R11 strobe offset reads 0", 32'(d), 32'h0);
    check_outs("R11 read of strobe offset");
    bus_addr = 4'd8; bus_wdata = 16'h0055; bus_byte = 1'b1;
    bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_byte = 1'b0;
    check("R12 read before write", 32'(bus_rdata), 32'h00E4);
    exp_rng = 8'h55;
    check_outs("R12 write lands");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sync_hold();
    t_bytes();
    t_immediate();
    t_range();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule